// File: doc/BRIEF.md
# I2C Target Byte Engine

This block is the serial front end of a small control peripheral that sits on a two-wire I2C bus as a target. A fast system clock oversamples the bus clock and data lines. The block recognises start, repeated start and stop conditions, and shifts bytes in and out MSB first. It answers its own seven-bit address and acknowledges by enabling an open-drain pull-down on the data line. The upper five address bits are a fixed prefix. The lower two come from strap pins, so up to four of these engines can share a bus.

Toward the command layer the engine reports every accepted byte as a one-cycle frame strobe. The strobe carries the byte index within the transaction, the byte value and the transfer direction. In a read, the data byte follows the address directly. The engine takes each byte to send from a parallel input at the end of the preceding acknowledge clock. A repeated start may follow a write without a stop, so a write that only selects a channel can be turned into a read at once.

Top module: `i2c_tgt_engine`

## Requirements
- R1: The address byte is accepted only when its bits 7..3 equal binary 01011 and its bits 2..1 equal `addr_sel_i[1]` and `addr_sel_i[0]`, in that order. Bit 0 is the direction: 1 means the master reads and 0 means it writes.
- R2: When the engine is addressed, it holds `sda_oe_o` high for the whole high phase of the ninth SCL pulse after the address byte and after each written data byte.
- R3: Each accepted byte gives exactly one single-cycle `frame_stb_o` pulse. The address byte reports index 0 with `frame_rnw_o` equal to its bit 0. Written data bytes report indices 1, 2, 3 and so on, with `frame_rnw_o` = 0. `frame_data_o` holds the byte as received MSB first.
- R4: In a read, the engine samples `tx_data_i` on the SCL falling edge that ends an acknowledge clock and shifts it out MSB first. A 0 bit sets `sda_oe_o` to 1 and a 1 bit sets it to 0. Changes to `tx_data_i` during the byte have no effect on it, and `sda_oe_o` rises only while SCL is low.
- R5: A master acknowledge (SDA low on the ninth clock of a read byte) makes the engine send the next byte. A master no-acknowledge makes it release SDA and ignore all further clocks until the next start or stop.
- R6: On an address mismatch the engine never pulls SDA and gives no strobe until the next start or stop.
- R7: A repeated start with no stop before it is accepted at any byte boundary. The byte after it is treated as a new address byte at index 0, and its direction may differ from the earlier one.
- R8: A start or stop seen in the middle of a byte drops the partial byte without a strobe. A stop returns the engine to idle with SDA released.
- R9: During reset, `sda_oe_o` and `frame_stb_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 2 | Strapped low address bits, bit 1 matches address bit 2 |
| tx_data_i | input | 8 | Byte to transmit in read transfers |
| sda_oe_o | output | 1 | 1 = pull the data line low, 0 = release |
| frame_stb_o | output | 1 | One-cycle pulse per accepted byte |
| frame_idx_o | output | 4 | Byte index within the transaction |
| frame_data_o | output | 8 | Received byte |
| frame_rnw_o | output | 1 | Direction of the transaction, 1 = read |

## Verification
The hardest state to reach from the ports is an abort in the middle of a byte. The stimulus has to place a repeated start or a stop after only a few bits have been clocked, while the shift register and bit counter hold partial state. Then it has to prove that the next full address is still decoded from a clean count. The bench has a bus-master model that can clock any number of bits before it issues a condition, and it uses that model to build these cases. The same model produces the direction change across a repeated start and the clocks sent after a no-acknowledge. The acknowledge-pin decode is swept over every strap setting against every address low-bit pair, and against all 32 prefixes.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_NEXT,
      ST_IGNORE
   } tgt_state_t;

   localparam int LINE_SCL = 0;
   localparam int LINE_SDA = 1;
   localparam int N_LINES  = 2;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int LINES  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] raw_i,
   output logic [LINES-1:0] lvl_o,
   output logic [LINES-1:0] rise_o,
   output logic [LINES-1:0] fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain_q;
      logic              prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
            prev_q  <= chain_q[STAGES-1];
         end
      end

      assign lvl_o[g]  = chain_q[STAGES-1];
      assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
      assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;
   end

endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
   input  logic scl_lvl,
   input  logic sda_rise,
   input  logic sda_fall,
   output logic start_evt,
   output logic stop_evt
);

   // SDA may only move while SCL is low; any SDA edge with SCL high is a condition.
   assign start_evt = sda_fall & scl_lvl;
   assign stop_evt  = sda_rise & scl_lvl;

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
   import i2c_tgt_pkg::*;
#(
   parameter int                  BYTE_W   = 8,
   parameter int                  PREFIX_W = 5,
   parameter int                  PIN_W    = 2,
   parameter logic [PREFIX_W-1:0] PREFIX   = 5'b01011,
   parameter int                  IDX_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_lvl,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic [PIN_W-1:0]  pins_i,
   input  logic [BYTE_W-1:0] tx_data_i,
   output logic              sda_oe_o,
   output logic              stb_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [BYTE_W-1:0] data_o,
   output logic              rnw_o
);

   localparam int BCW = $clog2(BYTE_W + 1);

   if (PREFIX_W + PIN_W + 1 != BYTE_W) begin : g_bad_split
      $error("i2c_tgt_fsm: prefix, pin bits and direction bit must fill one byte");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("i2c_tgt_fsm: IDX_W must be at least 1");
   end

   tgt_state_t         state_q;
   logic [BCW-1:0]     bit_q;
   logic [BYTE_W-1:0]  sr_q;
   logic [BYTE_W-1:0]  tx_q;
   logic [IDX_W-1:0]   idx_q;
   logic               rnw_q;
   logic               oe_q;
   logic               stb_q;
   logic [IDX_W-1:0]   fidx_q;
   logic [BYTE_W-1:0]  fdat_q;
   logic               frnw_q;

   logic [BYTE_W-1:0]  shift_nxt;
   logic               addr_hit;
   logic [IDX_W-1:0]   idx_inc;

   assign shift_nxt = {sr_q[BYTE_W-2:0], sda_lvl};
   assign addr_hit  = (shift_nxt[BYTE_W-1 -: PREFIX_W] == PREFIX) &&
                      (shift_nxt[PIN_W:1] == pins_i);
   assign idx_inc   = (idx_q == '1) ? idx_q : idx_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         sr_q    <= '0;
         tx_q    <= '0;
         idx_q   <= '0;
         rnw_q   <= 1'b0;
         oe_q    <= 1'b0;
         stb_q   <= 1'b0;
         fidx_q  <= '0;
         fdat_q  <= '0;
         frnw_q  <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         if (start_evt) begin
            state_q <= ST_RX;
            bit_q   <= '0;
            idx_q   <= '0;
            rnw_q   <= 1'b0;
            oe_q    <= 1'b0;
         end else if (stop_evt) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            oe_q    <= 1'b0;
         end else begin
            case (state_q)
               ST_RX: begin
                  if (scl_rise && (bit_q < BCW'(BYTE_W))) begin
                     sr_q  <= shift_nxt;
                     bit_q <= bit_q + 1'b1;
                     if (bit_q == BCW'(BYTE_W - 1)) begin
                        if (idx_q == '0) begin
                           if (addr_hit) begin
                              rnw_q  <= shift_nxt[0];
                              stb_q  <= 1'b1;
                              fidx_q <= '0;
                              fdat_q <= shift_nxt;
                              frnw_q <= shift_nxt[0];
                           end else begin
                              state_q <= ST_IGNORE;
                           end
                        end else begin
                           stb_q  <= 1'b1;
                           fidx_q <= idx_q;
                           fdat_q <= shift_nxt;
                           frnw_q <= 1'b0;
                        end
                     end
                  end else if (scl_fall && (bit_q == BCW'(BYTE_W))) begin
                     state_q <= ST_ACK;
                     oe_q    <= 1'b1;
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bit_q <= '0;
                     idx_q <= idx_inc;
                     if (rnw_q) begin
                        tx_q    <= tx_data_i;
                        oe_q    <= ~tx_data_i[BYTE_W-1];
                        state_q <= ST_TX;
                     end else begin
                        oe_q    <= 1'b0;
                        state_q <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bit_q <= bit_q + 1'b1;
                  end else if (scl_fall) begin
                     if (bit_q == BCW'(BYTE_W)) begin
                        oe_q    <= 1'b0;
                        state_q <= ST_MACK;
                     end else begin
                        tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                        oe_q <= ~tx_q[BYTE_W-2];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     state_q <= sda_lvl ? ST_IGNORE : ST_NEXT;
                  end
               end
               ST_NEXT: begin
                  if (scl_fall) begin
                     tx_q    <= tx_data_i;
                     oe_q    <= ~tx_data_i[BYTE_W-1];
                     bit_q   <= '0;
                     idx_q   <= idx_inc;
                     state_q <= ST_TX;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o = oe_q;
   assign stb_o    = stb_q;
   assign idx_o    = fidx_q;
   assign data_o   = fdat_q;
   assign rnw_o    = frnw_q;

   p_oe_rise_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> !scl_lvl);

   p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stb_q |=> !stb_q);

   p_ignore_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IGNORE) |-> (!oe_q && !stb_q));

   p_start_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> (state_q == ST_RX && bit_q == '0 && !oe_q));

   p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> (state_q == ST_IDLE && !oe_q));

   p_addr_prefix_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_q && fidx_q == '0) |-> (fdat_q[BYTE_W-1 -: PREFIX_W] == PREFIX));

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter int                  SYNC_STAGES = 2,
   parameter int                  BYTE_W      = 8,
   parameter int                  PREFIX_W    = 5,
   parameter int                  PIN_W       = 2,
   parameter logic [PREFIX_W-1:0] PREFIX      = 5'b01011,
   parameter int                  IDX_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [PIN_W-1:0]  addr_sel_i,
   input  logic [BYTE_W-1:0] tx_data_i,
   output logic              sda_oe_o,
   output logic              frame_stb_o,
   output logic [IDX_W-1:0]  frame_idx_o,
   output logic [BYTE_W-1:0] frame_data_o,
   output logic              frame_rnw_o
);

   logic [N_LINES-1:0] raw;
   logic [N_LINES-1:0] lvl;
   logic [N_LINES-1:0] rise;
   logic [N_LINES-1:0] fall;
   logic               start_evt;
   logic               stop_evt;

   assign raw[LINE_SCL] = scl_i;
   assign raw[LINE_SDA] = sda_i;

   i2c_tgt_sync #(
      .LINES  (N_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw),
      .lvl_o  (lvl),
      .rise_o (rise),
      .fall_o (fall)
   );

   i2c_tgt_cond u_cond (
      .scl_lvl   (lvl[LINE_SCL]),
      .sda_rise  (rise[LINE_SDA]),
      .sda_fall  (fall[LINE_SDA]),
      .start_evt (start_evt),
      .stop_evt  (stop_evt)
   );

   i2c_tgt_fsm #(
      .BYTE_W   (BYTE_W),
      .PREFIX_W (PREFIX_W),
      .PIN_W    (PIN_W),
      .PREFIX   (PREFIX),
      .IDX_W    (IDX_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_lvl   (lvl[LINE_SCL]),
      .scl_rise  (rise[LINE_SCL]),
      .scl_fall  (fall[LINE_SCL]),
      .sda_lvl   (lvl[LINE_SDA]),
      .start_evt (start_evt),
      .stop_evt  (stop_evt),
      .pins_i    (addr_sel_i),
      .tx_data_i (tx_data_i),
      .sda_oe_o  (sda_oe_o),
      .stb_o     (frame_stb_o),
      .idx_o     (frame_idx_o),
      .data_o    (frame_data_o),
      .rnw_o     (frame_rnw_o)
   );

endmodule

// File: tb/i2c_tgt_engine_test.sv
`timescale 1ns/1ps
module i2c_tgt_engine_test;

   localparam int Q = 10;
   localparam logic [4:0] PFX = 5'b01011;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] addr_sel = 2'b00;
   logic [7:0] tx_data = 8'h00;
   logic       sda_oe;
   logic       stb;
   logic [3:0] fidx;
   logic [7:0] fdat;
   logic       frnw;
   logic       sda_line;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [3:0] mon_idx [0:63];
   logic [7:0] mon_dat [0:63];
   logic       mon_rnw [0:63];
   int         mon_cnt = 0;

   always #2.5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   i2c_tgt_engine uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl_m),
      .sda_i        (sda_line),
      .addr_sel_i   (addr_sel),
      .tx_data_i    (tx_data),
      .sda_oe_o     (sda_oe),
      .frame_stb_o  (stb),
      .frame_idx_o  (fidx),
      .frame_data_o (fdat),
      .frame_rnw_o  (frnw)
   );

   always @(negedge clk) begin
      if (stb) begin
         mon_idx[mon_cnt % 64] = fidx;
         mon_dat[mon_cnt % 64] = fdat;
         mon_rnw[mon_cnt % 64] = frnw;
         mon_cnt = mon_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic hq(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; hq(1);
      sda_m = 1'b0; hq(1);
      scl_m = 1'b0; hq(1);
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; hq(1);
      scl_m = 1'b1; hq(1);
      sda_m = 1'b0; hq(1);
      scl_m = 1'b0; hq(1);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hq(1);
      scl_m = 1'b1; hq(1);
      sda_m = 1'b1; hq(2);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         sda_m = b[7-i]; hq(1);
         scl_m = 1'b1; hq(2);
         scl_m = 1'b0; hq(1);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      sda_m = 1'b1; hq(1);
      scl_m = 1'b1; hq(1);
      ack = ~sda_line;
      hq(1);
      scl_m = 1'b0; hq(1);
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit mack, input logic [7:0] nxt);
      sda_m = 1'b1;
      hq(1);
      for (int i = 0; i < 8; i++) begin
         scl_m = 1'b1; hq(1);
         b[7-i] = sda_line;
         if (i == 3) tx_data = nxt;
         hq(1);
         scl_m = 1'b0; hq(2);
      end
      sda_m = mack ? 1'b0 : 1'b1; hq(1);
      scl_m = 1'b1; hq(2);
      scl_m = 1'b0; hq(1);
      sda_m = 1'b1; hq(1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      bit         ack;
      int         base;
      logic [7:0] rb;
      logic [7:0] exp_tx [0:2];

      // R9: outputs quiet during reset
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R9 oe in reset", int'(sda_oe), 0);
      chk(stb == 1'b0, "R9 strobe in reset", int'(stb), 0);
      rst_n = 1'b1;
      hq(2);

      // R1/R2/R6: every strap setting against every address low-bit pair
      for (int p = 0; p < 4; p++) begin
         for (int a = 0; a < 4; a++) begin
            addr_sel = 2'(p);
            hq(1);
            base = mon_cnt;
            bus_start();
            send_byte({PFX, 2'(a), 1'b0}, ack);
            chk(ack == (a == p), "R1 R2 address ack", int'(ack), int'(a == p));
            send_byte(8'h00, ack);
            if (a == p) begin
               chk(ack == 1'b1, "R2 data ack", int'(ack), 1);
               chk(mon_cnt - base == 2, "R3 strobe count", mon_cnt - base, 2);
               chk(mon_dat[(base + 1) % 64] == 8'h00 && mon_idx[(base + 1) % 64] == 4'd1,
                   "R3 data strobe", int'(mon_dat[(base + 1) % 64]), 0);
            end else begin
               chk(ack == 1'b0, "R6 ignored byte not acked", int'(ack), 0);
               chk(mon_cnt == base, "R6 no strobe after mismatch", mon_cnt - base, 0);
            end
            bus_stop();
         end
      end

      // R1: prefix sweep with straps at 2'b10
      addr_sel = 2'b10;
      for (int pf = 0; pf < 32; pf++) begin
         base = mon_cnt;
         bus_start();
         send_byte({5'(pf), 2'b10, 1'b0}, ack);
         chk(ack == (5'(pf) == PFX), "R1 prefix decode", int'(ack), int'(5'(pf) == PFX));
         chk((mon_cnt - base) == ((5'(pf) == PFX) ? 1 : 0), "R1 prefix strobe",
             mon_cnt - base, (5'(pf) == PFX) ? 1 : 0);
         bus_stop();
      end

      // R3: multi-byte write, indices and data
      base = mon_cnt;
      bus_start();
      send_byte({PFX, 2'b10, 1'b0}, ack);
      for (int k = 0; k < 3; k++) begin
         send_byte(8'(8'hA5 ^ (k * 37)), ack);
         chk(ack == 1'b1, "R2 write byte ack", int'(ack), 1);
      end
      bus_stop();
      chk(mon_cnt - base == 4, "R3 write strobe count", mon_cnt - base, 4);
      chk(mon_idx[base % 64] == 4'd0 && mon_rnw[base % 64] == 1'b0 &&
          mon_dat[base % 64] == {PFX, 2'b10, 1'b0}, "R3 address strobe",
          int'(mon_dat[base % 64]), int'({PFX, 2'b10, 1'b0}));
      for (int k = 0; k < 3; k++) begin
         chk(mon_idx[(base + 1 + k) % 64] == 4'(k + 1) &&
             mon_dat[(base + 1 + k) % 64] == 8'(8'hA5 ^ (k * 37)) &&
             mon_rnw[(base + 1 + k) % 64] == 1'b0, "R3 write data strobe",
             int'(mon_dat[(base + 1 + k) % 64]), int'(8'(8'hA5 ^ (k * 37))));
      end
      chk(sda_oe == 1'b0, "R8 released after stop", int'(sda_oe), 0);

      // R4/R5: read of three bytes, tx changed mid-byte
      exp_tx[0] = 8'h5A; exp_tx[1] = 8'hFF; exp_tx[2] = 8'h00;
      tx_data = exp_tx[0];
      base = mon_cnt;
      bus_start();
      send_byte({PFX, 2'b10, 1'b1}, ack);
      chk(ack == 1'b1, "R2 read address ack", int'(ack), 1);
      chk(mon_cnt - base == 1 && mon_idx[base % 64] == 4'd0 && mon_rnw[base % 64] == 1'b1,
          "R3 read address strobe", int'(mon_rnw[base % 64]), 1);
      for (int k = 0; k < 3; k++) begin
         recv_byte(rb, k < 2, (k < 2) ? exp_tx[k + 1] : 8'hC3);
         chk(rb == exp_tx[k], "R4 R5 read byte", int'(rb), int'(exp_tx[k]));
      end
      chk(sda_oe == 1'b0, "R5 released after nack", int'(sda_oe), 0);
      send_byte(8'h00, ack);
      chk(ack == 1'b0, "R5 clocks after nack ignored", int'(ack), 0);
      chk(mon_cnt - base == 1, "R5 no strobe after nack", mon_cnt - base, 1);
      bus_stop();

      // R7: write selects, repeated start turns it into a read
      tx_data = 8'h96;
      base = mon_cnt;
      bus_start();
      send_byte({PFX, 2'b10, 1'b0}, ack);
      send_byte(8'h40, ack);
      bus_rstart();
      send_byte({PFX, 2'b10, 1'b1}, ack);
      chk(ack == 1'b1, "R7 address after repeated start", int'(ack), 1);
      recv_byte(rb, 1'b0, 8'h96);
      chk(rb == 8'h96, "R7 read after repeated start", int'(rb), 8'h96);
      bus_stop();
      chk(mon_cnt - base == 3, "R7 strobe count", mon_cnt - base, 3);
      chk(mon_idx[(base + 1) % 64] == 4'd1 && mon_dat[(base + 1) % 64] == 8'h40,
          "R7 selection byte", int'(mon_dat[(base + 1) % 64]), 8'h40);
      chk(mon_idx[(base + 2) % 64] == 4'd0 && mon_rnw[(base + 2) % 64] == 1'b1,
          "R7 index reset and direction", int'(mon_idx[(base + 2) % 64]), 0);

      // R8: repeated start after four bits of an address
      base = mon_cnt;
      bus_start();
      send_bits(8'hFF, 4);
      bus_rstart();
      send_byte({PFX, 2'b10, 1'b0}, ack);
      chk(ack == 1'b1, "R8 clean decode after mid-byte start", int'(ack), 1);
      send_byte(8'h3C, ack);
      send_bits(8'h81, 3);
      bus_rstart();
      send_byte({PFX, 2'b10, 1'b0}, ack);
      bus_stop();
      chk(mon_cnt - base == 3, "R8 partial byte dropped", mon_cnt - base, 3);
      chk(mon_idx[(base + 2) % 64] == 4'd0, "R8 index reset", int'(mon_idx[(base + 2) % 64]), 0);

      // R8: stop after three data bits
      base = mon_cnt;
      bus_start();
      send_byte({PFX, 2'b10, 1'b0}, ack);
      send_bits(8'h00, 3);
      bus_stop();
      chk(sda_oe == 1'b0, "R8 released after mid-byte stop", int'(sda_oe), 0);
      chk(mon_cnt - base == 1, "R8 no strobe for partial byte", mon_cnt - base, 1);

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule